// File: doc/BRIEF.md
# Display Link Command Packet Port

This block is the command path of a display serial link host. Software stages a command payload by writing 32-bit words into a transmit payload queue. It then writes a header word, and that write launches the packet. A serializer sends the three header bytes and the payload bytes one at a time toward a link model. Every byte of the packet carries a flag that selects low-power or high-speed transmission.

Responses from the link arrive as a byte stream. A parser splits each response into a header word and, for long responses, payload words. Software polls a status word to learn whether the command path is busy, whether any payload queue holds data, and whether a response is waiting. It then reads the response through two read registers. ECC and CRC bytes, lane signalling and escape sequences are handled elsewhere.

Register word addresses are 0 for transmit payload (write), 1 for transmit header (write), 2 for status (read), 3 for receive header (read) and 4 for receive payload (read). Read data appears on `bus_rdata` one clock after `bus_rd` is asserted.

Top module: `dsi_cmd_port`

## Requirements
- R1: After reset the status word reads 0 and `tx_valid` is low.
- R2: A header write launches a packet. The packet is sent as header bits 7:0, 15:8 and 23:16. When bit 3 of the first header byte is 1 (long type) and the count in header bits 23:8 is nonzero, that many payload bytes follow. They are taken from the staged payload words least significant byte first, and the padding bytes of a final partial word are dropped. `tx_last` marks the final byte.
- R3: Header bit 24 is driven on `tx_lp` for every byte of that packet: 1 means low power, 0 means high speed.
- R4: Status bit 16 (busy) is 1 from the cycle after a header commit until the final byte is accepted. While `tx_ready` is low, the offered byte and `tx_last` hold steady.
- R5: A header written while busy is dropped and sends nothing. It sets status bit 19, which stays set until reset.
- R6: Status bit 17 is 1 while either the transmit or the receive payload queue holds a word.
- R7: A response is received as three header bytes. For a short response (first byte bit 3 clear, or a zero count), status bit 18 rises once the header is complete. The receive header register returns the three bytes in bits 7:0, 15:8 and 23:16 (data type in bits 5:0). Reading that register clears bit 18.
- R8: For a long response, the payload bytes are packed little-endian into words, with a partial last word zero padded. Bit 18 rises after the last byte. The receive header register then holds the count in bits 23:8, and bit 18 clears on the receive payload read that returns the last word.
- R9: Response bytes that arrive while bit 18 is set are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after `bus_rd` |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_ready | input | 1 | Link accepts outgoing byte |
| tx_byte | output | 8 | Outgoing byte |
| tx_last | output | 1 | Final byte of packet |
| tx_lp | output | 1 | Low-power select for the current packet |
| rx_valid | input | 1 | Response byte valid |
| rx_byte | input | 8 | Response byte |

## Verification
The bench uses the default queue depths of four words on each side. A 7-byte long command therefore spans a full word plus a padded word, and an exact 4-byte payload and a zero-count long header cover the word-boundary edges. A link-ready pattern that drops every third cycle forces stalls in the middle of both header and payload bytes. A second header is issued inside the busy window, and a long response of five bytes exercises padding on the receive side.

// File: rtl/dsi_cmd_pkg.sv
package dsi_cmd_pkg;
  localparam int WC_W = 16;
  localparam logic [2:0] A_TXPLD = 3'd0;
  localparam logic [2:0] A_TXHDR = 3'd1;
  localparam logic [2:0] A_STAT  = 3'd2;
  localparam logic [2:0] A_RXHDR = 3'd3;
  localparam logic [2:0] A_RXPLD = 3'd4;
  localparam int ST_BUSY  = 16;
  localparam int ST_NE    = 17;
  localparam int ST_AVAIL = 18;
  localparam int ST_OVF   = 19;
  localparam int LP_BIT   = 24;

  typedef enum logic [1:0] {SR_IDLE, SR_HDR, SR_PLD} ser_st_t;
  typedef enum logic [1:0] {PR_HDR, PR_PLD, PR_HOLD} par_st_t;

  // long packet types carry a payload; bit 3 of the type byte marks them
  function automatic logic is_long(input logic [7:0] dt);
    return dt[3];
  endfunction
endpackage

// File: rtl/cmd_fifo.sv
module cmd_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic full, do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == (AW+1)'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + AW'(1);
      if (do_pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + AW'(1);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + (AW+1)'(1);
        2'b01:   cnt <= cnt - (AW+1)'(1);
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/dsi_tx_serializer.sv
module dsi_tx_serializer
  import dsi_cmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        commit,
  input  logic [24:0] hdr_in,
  input  logic [31:0] pld_word,
  input  logic        pld_empty,
  output logic        pld_pop,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_byte,
  output logic        tx_last,
  output logic        tx_lp,
  output logic        busy
);
  ser_st_t st;
  logic [24:0] hdr_q;
  logic [1:0]  bidx, sel;
  logic [WC_W-1:0] rem;
  logic [WC_W-1:0] wc;
  logic has_pld, fire;

  assign wc       = hdr_q[8 +: WC_W];
  assign has_pld  = is_long(hdr_q[7:0]) && (wc != '0);
  assign tx_valid = (st == SR_HDR) || ((st == SR_PLD) && !pld_empty);
  assign tx_byte  = (st == SR_PLD) ? pld_word[{sel, 3'b000} +: 8] : hdr_q[{bidx, 3'b000} +: 8];
  assign tx_last  = ((st == SR_HDR) && (bidx == 2'd2) && !has_pld) ||
                    ((st == SR_PLD) && (rem == WC_W'(1)) && !pld_empty);
  assign tx_lp    = hdr_q[LP_BIT];
  assign fire     = tx_valid && tx_ready;
  assign pld_pop  = fire && (st == SR_PLD) && ((sel == 2'd3) || (rem == WC_W'(1)));
  assign busy     = (st != SR_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= SR_IDLE;
      hdr_q <= '0;
      bidx  <= '0;
      sel   <= '0;
      rem   <= '0;
    end else begin
      case (st)
        SR_IDLE: if (commit) begin
          hdr_q <= hdr_in;
          bidx  <= '0;
          st    <= SR_HDR;
        end
        SR_HDR: if (fire) begin
          if (bidx == 2'd2) begin
            sel <= '0;
            rem <= wc;
            st  <= has_pld ? SR_PLD : SR_IDLE;
          end else begin
            bidx <= bidx + 2'd1;
          end
        end
        SR_PLD: if (fire) begin
          sel <= sel + 2'd1;
          rem <= rem - WC_W'(1);
          if (rem == WC_W'(1)) st <= SR_IDLE;
        end
        default: st <= SR_IDLE;
      endcase
    end
  end

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte) && $stable(tx_last)));
  // R5
  drop_chk: assert property (@(posedge clk) disable iff (rst)
    (commit && busy) |=> $stable(hdr_q));
  // R4
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(commit));
  // R2
  end_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && tx_last) |=> !busy);
endmodule

// File: rtl/dsi_rx_parser.sv
module dsi_rx_parser
  import dsi_cmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        rx_valid,
  input  logic [7:0]  rx_byte,
  input  logic        hdr_rd,
  input  logic        pld_rd,
  output logic        push,
  output logic [31:0] push_word,
  output logic [23:0] hdr_word,
  output logic        avail
);
  par_st_t st;
  logic [7:0]  b0, b1, b2;
  logic [1:0]  cnt, sel;
  logic [WC_W-1:0] rem;
  logic [31:0] pack, pack_next;
  logic [WC_W-2:0] words_left;
  logic [WC_W-1:0] wc_in;
  logic [WC_W:0]   wsum;

  assign pack_next = pack | ({24'd0, rx_byte} << {sel, 3'b000});
  assign push      = rx_valid && (st == PR_PLD) && ((sel == 2'd3) || (rem == WC_W'(1)));
  assign push_word = pack_next;
  assign hdr_word  = {b2, b1, b0};
  assign avail     = (st == PR_HOLD);
  assign wc_in     = {rx_byte, b1};
  assign wsum      = {1'b0, wc_in} + (WC_W+1)'(3);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= PR_HDR;
      b0 <= '0; b1 <= '0; b2 <= '0;
      cnt <= '0; sel <= '0; rem <= '0;
      pack <= '0; words_left <= '0;
    end else begin
      case (st)
        PR_HDR: if (rx_valid) begin
          case (cnt)
            2'd0:    b0 <= rx_byte;
            2'd1:    b1 <= rx_byte;
            default: b2 <= rx_byte;
          endcase
          if (cnt == 2'd2) begin
            cnt  <= '0;
            sel  <= '0;
            pack <= '0;
            rem  <= wc_in;
            if (is_long(b0) && (wc_in != '0)) begin
              words_left <= wsum[WC_W:2];
              st <= PR_PLD;
            end else begin
              words_left <= '0;
              st <= PR_HOLD;
            end
          end else begin
            cnt <= cnt + 2'd1;
          end
        end
        PR_PLD: if (rx_valid) begin
          sel  <= sel + 2'd1;
          rem  <= rem - WC_W'(1);
          pack <= push ? '0 : pack_next;
          if (rem == WC_W'(1)) st <= PR_HOLD;
        end
        PR_HOLD: begin
          if (words_left == '0) begin
            if (hdr_rd) st <= PR_HDR;
          end else if (pld_rd) begin
            words_left <= words_left - (WC_W-1)'(1);
            if (words_left == (WC_W-1)'(1)) st <= PR_HDR;
          end
        end
        default: st <= PR_HDR;
      endcase
    end
  end

  // R7
  avail_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(avail) |-> $past(hdr_rd || pld_rd));
  // R9
  ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (avail && rx_valid) |=> $stable(hdr_word));
endmodule

// File: rtl/dsi_cmd_port.sv
module dsi_cmd_port
  import dsi_cmd_pkg::*;
#(
  parameter int TXQ_DEPTH = 4,
  parameter int RXQ_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_byte,
  output logic        tx_last,
  output logic        tx_lp,
  input  logic        rx_valid,
  input  logic [7:0]  rx_byte
);
  logic txq_push, txq_pop, txq_empty;
  logic [31:0] txq_dout;
  logic rxq_push, rxq_pop, rxq_empty;
  logic [31:0] rxq_din, rxq_dout;
  logic hdr_wr, hdr_rd, pld_rd, busy, avail, ovf_q;
  logic [23:0] rx_hdr;
  logic [31:0] stat;

  assign txq_push = bus_wr && (bus_addr == A_TXPLD);
  assign hdr_wr   = bus_wr && (bus_addr == A_TXHDR);
  assign hdr_rd   = bus_rd && (bus_addr == A_RXHDR);
  assign pld_rd   = bus_rd && (bus_addr == A_RXPLD);
  assign rxq_pop  = pld_rd;

  cmd_fifo #(.W(32), .DEPTH(TXQ_DEPTH)) u_txq (
    .clk(clk), .rst(rst), .push(txq_push), .din(bus_wdata),
    .pop(txq_pop), .dout(txq_dout), .empty(txq_empty));

  cmd_fifo #(.W(32), .DEPTH(RXQ_DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .push(rxq_push), .din(rxq_din),
    .pop(rxq_pop), .dout(rxq_dout), .empty(rxq_empty));

  dsi_tx_serializer u_ser (
    .clk(clk), .rst(rst), .commit(hdr_wr), .hdr_in(bus_wdata[24:0]),
    .pld_word(txq_dout), .pld_empty(txq_empty), .pld_pop(txq_pop),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_byte(tx_byte),
    .tx_last(tx_last), .tx_lp(tx_lp), .busy(busy));

  dsi_rx_parser u_par (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .hdr_rd(hdr_rd), .pld_rd(pld_rd), .push(rxq_push), .push_word(rxq_din),
    .hdr_word(rx_hdr), .avail(avail));

  always_comb begin
    stat = '0;
    stat[ST_BUSY]  = busy;
    stat[ST_NE]    = !txq_empty || !rxq_empty;
    stat[ST_AVAIL] = avail;
    stat[ST_OVF]   = ovf_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_q     <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (hdr_wr && busy) ovf_q <= 1'b1;
      if (bus_rd) begin
        case (bus_addr)
          A_STAT:  bus_rdata <= stat;
          A_RXHDR: bus_rdata <= {8'd0, rx_hdr};
          A_RXPLD: bus_rdata <= rxq_empty ? '0 : rxq_dout;
          default: bus_rdata <= '0;
        endcase
      end
    end
  end

  // R5
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_q |=> ovf_q);
endmodule

// File: tb/dsi_cmd_port_test.sv
module dsi_cmd_port_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic tx_valid, tx_last, tx_lp;
  logic tx_ready = 1'b0;
  logic [7:0] tx_byte;
  logic rx_valid = 1'b0;
  logic [7:0] rx_byte = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [9:0] exp_q [$];
  logic [1:0] rdy_cnt = '0;

  always #10 clk = ~clk;

  dsi_cmd_port uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_byte(tx_byte),
    .tx_last(tx_last), .tx_lp(tx_lp), .rx_valid(rx_valid), .rx_byte(rx_byte));

  // link ready pattern: low one cycle in three
  always @(posedge clk) begin
    rdy_cnt  <= (rdy_cnt == 2'd2) ? 2'd0 : rdy_cnt + 2'd1;
    tx_ready <= (rdy_cnt != 2'd1);
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard monitor for the outgoing byte stream (R2, R3)
  always @(negedge clk) begin
    if (!rst && tx_valid && tx_ready) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R2 unexpected byte: actual %h expected none", {tx_lp, tx_last, tx_byte});
      end else begin
        logic [9:0] e;
        e = exp_q.pop_front();
        if ({tx_lp, tx_last, tx_byte} !== e) begin
          errors++;
          $display("FAIL R2/R3 byte {lp,last,data}: actual %h expected %h",
                   {tx_lp, tx_last, tx_byte}, e);
        end
      end
    end
  end

  task automatic expect_byte(input logic lp, input logic last, input logic [7:0] b);
    exp_q.push_back({lp, last, b});
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic send_rx(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 60; i++) begin
      bus_read(3'd2, s);
      if (!s[16]) break;
    end
    repeat (2) @(negedge clk);
    check("R2 stream drained (queue size)", exp_q.size(), 0);
  endtask

  initial begin
    logic [31:0] d;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 tx_valid after reset", {31'd0, tx_valid}, 0);
    bus_read(3'd2, d);
    check("R1 status after reset", d, 32'h0);

    // R2 short packet, R5 header during busy is dropped
    expect_byte(1'b0, 1'b0, 8'h05);
    expect_byte(1'b0, 1'b0, 8'hA5);
    expect_byte(1'b0, 1'b1, 8'h5A);
    bus_write(3'd1, 32'h005AA505);
    bus_write(3'd1, 32'h01112201);
    bus_read(3'd2, d);
    check("R5 overflow bit after dropped header", {31'd0, d[19]}, 1);
    wait_idle();

    // R3/R6/R4 long low-power packet of 7 bytes
    bus_write(3'd0, 32'h14131211);
    bus_write(3'd0, 32'h00171615);
    bus_read(3'd2, d);
    check("R6 fifos-not-empty with staged payload", {31'd0, d[17]}, 1);
    expect_byte(1'b1, 1'b0, 8'h39);
    expect_byte(1'b1, 1'b0, 8'h07);
    expect_byte(1'b1, 1'b0, 8'h00);
    for (int i = 0; i < 7; i++) expect_byte(1'b1, i == 6, 8'h11 + 8'(i));
    bus_write(3'd1, 32'h01000739);
    bus_read(3'd2, d);
    check("R4 busy after commit", {31'd0, d[16]}, 1);
    wait_idle();
    bus_read(3'd2, d);
    check("R6/R5 status after long packet (only sticky overflow)", d, 32'h00080000);

    // R2 exact word payload, high speed
    bus_write(3'd0, 32'hDDCCBBAA);
    expect_byte(1'b0, 1'b0, 8'h29);
    expect_byte(1'b0, 1'b0, 8'h04);
    expect_byte(1'b0, 1'b0, 8'h00);
    expect_byte(1'b0, 1'b0, 8'hAA);
    expect_byte(1'b0, 1'b0, 8'hBB);
    expect_byte(1'b0, 1'b0, 8'hCC);
    expect_byte(1'b0, 1'b1, 8'hDD);
    bus_write(3'd1, 32'h00000429);
    wait_idle();

    // R2 long type with zero count sends header only
    expect_byte(1'b1, 1'b0, 8'h29);
    expect_byte(1'b1, 1'b0, 8'h00);
    expect_byte(1'b1, 1'b1, 8'h00);
    bus_write(3'd1, 32'h01000029);
    wait_idle();

    // R7 short response
    send_rx(8'h21); send_rx(8'h9C); send_rx(8'h01);
    bus_read(3'd2, d);
    check("R7 avail after short response", {31'd0, d[18]}, 1);
    // R9 bytes while avail are discarded
    send_rx(8'h1C); send_rx(8'h02); send_rx(8'h00);
    bus_read(3'd3, d);
    check("R7/R9 short response header word", d, 32'h00019C21);
    bus_read(3'd2, d);
    check("R7/R9 status after header read", d & 32'h00060000, 32'h0);

    // R8 long response of 5 bytes
    send_rx(8'h1C); send_rx(8'h05); send_rx(8'h00);
    for (int i = 0; i < 5; i++) send_rx(8'hA1 + 8'(i));
    bus_read(3'd2, d);
    check("R8/R6 avail and not-empty after long response", d & 32'h00060000, 32'h00060000);
    bus_read(3'd3, d);
    check("R8 long response header word", d, 32'h0000051C);
    bus_read(3'd4, d);
    check("R8 first payload word", d, 32'hA4A3A2A1);
    bus_read(3'd2, d);
    check("R8 avail held before last word", {31'd0, d[18]}, 1);
    bus_read(3'd4, d);
    check("R8 padded last payload word", d, 32'h000000A5);
    bus_read(3'd2, d);
    check("R8 status after last word (R5 sticky)", d, 32'h00080000);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule